// File: doc/BRIEF.md
# Digital Input Glitch Filter and Change Detector

This block conditions a bank of asynchronous digital input lines (48 by default) before any logic downstream sees them. Every line first passes through a two-flop synchronizer into the system clock domain. A qualification stage then removes short glitches. It advances only on cycles where the filter clock enable is high, and a line's output moves to a new level only once that level has been seen on enough consecutive enables. Each line can instead skip qualification and pass its synchronized value straight through.

The qualification stage has two modes. In line mode every line qualifies on its own. In bus mode the bank is treated as one word, so a change on any line restarts qualification for all lines. A transition that is still pending on one line is then held back until the whole word has been stable for the full window.

On the conditioned outputs, a change detector watches for rising edges on lines set in one mask and falling edges on lines set in a second mask. A qualifying edge produces a one-cycle event pulse. In the same cycle, the conditioned word is latched into a snapshot register. Consumers acknowledge the snapshot. If a new event arrives while the previous one is still unacknowledged, a sticky overrun flag is raised.

Top module: `din_cond_top`

## Requirements
- R1: While reset is applied and right after it, `dout_filt`, `chg_event`, `snap_data` and `overrun` are all zero (all inputs low).
- R2: In line mode (`flt_bus_mode`=0) a non-bypassed output takes a new level only after its synchronized input has shown that level on two consecutive `flt_tick` cycles. One such cycle is not enough, and without `flt_tick` no non-bypassed output changes.
- R3: In line mode, a glitch on one line does not delay or alter the qualification of any other line.
- R4: In bus mode (`flt_bus_mode`=1), a change of any line between two ticks restarts qualification for every line. A pending transition is applied only on the tick that completes two consecutive ticks with an unchanged word.
- R5: A line whose `flt_bypass` bit is 1 drives `dout_filt` directly from its synchronized input, without waiting for ticks.
- R6: `chg_event` is a one-cycle pulse, asserted the cycle after `dout_filt` shows a 0-to-1 edge on a line with its `rise_en` bit set or a 1-to-0 edge on a line with its `fall_en` bit set. Edges on lines whose matching mask bit is 0 raise no event.
- R7: `overrun` is set when an event is detected while the previous event is unacknowledged. `snap_ack` high clears that pending state, and an ack in the same cycle as a new detection counts as acknowledging the older event. `overrun` is cleared only by reset.
- R8: `snap_data` takes the value `dout_filt` had in the cycle the edge appeared, in the same cycle as `chg_event`, and holds it in every cycle without an event.
- R9: An input change reaches the synchronized value two rising clock edges after it is applied, so a bypassed line shows it at `dout_filt` after the second edge and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din_async | input | N_LINES | Raw asynchronous input lines |
| flt_tick | input | 1 | Filter clock enable, one sample per high cycle |
| flt_bus_mode | input | 1 | 0 = per-line qualification, 1 = whole-bus qualification |
| flt_bypass | input | N_LINES | Per-line bypass of the qualification stage |
| rise_en | input | N_LINES | Per-line enable for rising-edge events |
| fall_en | input | N_LINES | Per-line enable for falling-edge events |
| snap_ack | input | 1 | Acknowledges the current snapshot |
| dout_filt | output | N_LINES | Conditioned line values |
| chg_event | output | 1 | One-cycle change-detection pulse |
| snap_data | output | N_LINES | Conditioned word captured at the last event |
| overrun | output | 1 | Sticky flag: event arrived before acknowledgement |

## Verification
The qualification stage is driven with three patterns. The first is a clean single-line step checked after one tick and after two, which separates the two-tick rule from a one-tick one. The second pairs a settling transition on one line with a one-tick glitch on another; run in both modes, it separates independent per-line counting from the restart applied to the whole bus. The third is a wide multi-line word switched in one step. The change detector is tried with edges whose mask bit is cleared, edges on the opposite polarity, and two events without an acknowledgement in between. Snapshots are compared against a queue of expected words, and the snapshot is checked again after an unmasked change to confirm it holds.

// File: rtl/din_cond_pkg.sv
package din_cond_pkg;
  // Qualification mode of the glitch filter
  typedef enum logic {
    FM_LINE = 1'b0,
    FM_BUS  = 1'b1
  } filt_mode_e;
endpackage

// File: rtl/din_rst_sync.sv
module din_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/din_sync.sv
module din_sync #(
  parameter int W      = 48,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [STAGES-1:0][W-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/din_glitch_filt.sv
module din_glitch_filt
  import din_cond_pkg::*;
#(
  parameter int N          = 48,
  parameter int FILT_TICKS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  filt_mode_e   mode,
  input  logic [N-1:0] samp_i,
  output logic [N-1:0] filt_o
);
  localparam int              CW   = $clog2(FILT_TICKS + 1);
  localparam logic [CW-1:0]   CMAX = CW'(FILT_TICKS);
  localparam logic [CW-1:0]   CONE = CW'(1);

  logic [N-1:0]          prev_q, prev_d;
  logic [N-1:0]          out_q, out_d;
  logic [N-1:0][CW-1:0]  lcnt_q, lcnt_d;
  logic [CW-1:0]         bcnt_q, bcnt_d;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == CMAX) ? v : v + CONE;
  endfunction

  // Next state: run lengths of unchanged samples, per line and for the bus
  always_comb begin
    prev_d = prev_q;
    lcnt_d = lcnt_q;
    bcnt_d = bcnt_q;
    out_d  = out_q;
    if (tick) begin
      prev_d = samp_i;
      bcnt_d = (samp_i == prev_q) ? sat_inc(bcnt_q) : CONE;
      for (int i = 0; i < N; i++) begin
        lcnt_d[i] = (samp_i[i] == prev_q[i]) ? sat_inc(lcnt_q[i]) : CONE;
      end
      if (mode == FM_BUS) begin
        if (bcnt_d == CMAX) out_d = samp_i;
      end else begin
        for (int i = 0; i < N; i++) begin
          if (lcnt_d[i] == CMAX) out_d[i] = samp_i[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      out_q  <= '0;
      lcnt_q <= '0;
      bcnt_q <= '0;
    end else begin
      prev_q <= prev_d;
      out_q  <= out_d;
      lcnt_q <= lcnt_d;
      bcnt_q <= bcnt_d;
    end
  end

  assign filt_o = out_q;
endmodule

// File: rtl/din_chg_det.sv
module din_chg_det #(
  parameter int N = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] data_i,
  input  logic [N-1:0] rise_en,
  input  logic [N-1:0] fall_en,
  input  logic         ack,
  output logic         event_o,
  output logic [N-1:0] snap_o,
  output logic         overrun_o
);
  logic [N-1:0] last_q;
  logic [N-1:0] snap_q, snap_d;
  logic         evt_q, evt_d;
  logic         pend_q, pend_d;
  logic         ovr_q, ovr_d;
  logic [N-1:0] rise_hit, fall_hit;
  logic         hit;

  always_comb begin
    rise_hit = data_i & ~last_q & rise_en;
    fall_hit = ~data_i & last_q & fall_en;
    hit      = |(rise_hit | fall_hit);
    evt_d    = hit;
    snap_d   = hit ? data_i : snap_q;
    pend_d   = hit ? 1'b1 : (ack ? 1'b0 : pend_q);
    ovr_d    = ovr_q | (hit & pend_q & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      snap_q <= '0;
      evt_q  <= 1'b0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      last_q <= data_i;
      snap_q <= snap_d;
      evt_q  <= evt_d;
      pend_q <= pend_d;
      ovr_q  <= ovr_d;
    end
  end

  assign event_o   = evt_q;
  assign snap_o    = snap_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/din_cond_top.sv
module din_cond_top
  import din_cond_pkg::*;
#(
  parameter int N_LINES     = 48,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TICKS  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] din_async,
  input  logic               flt_tick,
  input  logic               flt_bus_mode,
  input  logic [N_LINES-1:0] flt_bypass,
  input  logic [N_LINES-1:0] rise_en,
  input  logic [N_LINES-1:0] fall_en,
  input  logic               snap_ack,
  output logic [N_LINES-1:0] dout_filt,
  output logic               chg_event,
  output logic [N_LINES-1:0] snap_data,
  output logic               overrun
);
  logic               rst_n_int;
  logic [N_LINES-1:0] din_sync_w;
  logic [N_LINES-1:0] din_qual_w;
  filt_mode_e         mode_w;

  assign mode_w = filt_mode_e'(flt_bus_mode);

  din_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  din_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .d_async (din_async),
    .d_sync  (din_sync_w)
  );

  din_glitch_filt #(.N(N_LINES), .FILT_TICKS(FILT_TICKS)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .tick   (flt_tick),
    .mode   (mode_w),
    .samp_i (din_sync_w),
    .filt_o (din_qual_w)
  );

  assign dout_filt = (din_sync_w & flt_bypass) | (din_qual_w & ~flt_bypass);

  din_chg_det #(.N(N_LINES)) u_det (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .data_i    (dout_filt),
    .rise_en   (rise_en),
    .fall_en   (fall_en),
    .ack       (snap_ack),
    .event_o   (chg_event),
    .snap_o    (snap_data),
    .overrun_o (overrun)
  );
endmodule

// File: rtl/din_cond_chk.sv
module din_cond_chk #(
  parameter int N = 48
) (
  input logic         clk,
  input logic         rst_n,
  input logic         flt_tick,
  input logic [N-1:0] flt_bypass,
  input logic [N-1:0] rise_en,
  input logic [N-1:0] fall_en,
  input logic [N-1:0] dout_filt,
  input logic         chg_event,
  input logic [N-1:0] snap_data,
  input logic         overrun
);
  // R2: qualified lines move only on a tick
  p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_tick |=> ((dout_filt & ~(flt_bypass | $past(flt_bypass))) ==
                   ($past(dout_filt) & ~(flt_bypass | $past(flt_bypass)))));

  // R6: an event needs some edge enable in the detection cycle
  p_event_needs_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chg_event |-> (($past(rise_en) | $past(fall_en)) != '0));

  // R7: overrun is sticky
  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R7: overrun rises only together with an event
  p_overrun_with_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> chg_event);

  // R8: snapshot holds when no event is signalled
  p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_event |-> $stable(snap_data));
endmodule

bind din_cond_top din_cond_chk #(.N(N_LINES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flt_tick   (flt_tick),
  .flt_bypass (flt_bypass),
  .rise_en    (rise_en),
  .fall_en    (fall_en),
  .dout_filt  (dout_filt),
  .chg_event  (chg_event),
  .snap_data  (snap_data),
  .overrun    (overrun)
);

// File: tb/din_cond_top_tb.sv
`timescale 1ns/1ps
module din_cond_top_tb;
  localparam int N = 48;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] din_async;
  logic         flt_tick;
  logic         flt_bus_mode;
  logic [N-1:0] flt_bypass;
  logic [N-1:0] rise_en;
  logic [N-1:0] fall_en;
  logic         snap_ack;
  logic [N-1:0] dout_filt;
  logic         chg_event;
  logic [N-1:0] snap_data;
  logic         overrun;

  int n_cmp;
  int n_bad;
  int n_evt;
  logic [N-1:0] exp_q[$];
  logic         done;

  din_cond_top #(.N_LINES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .din_async(din_async), .flt_tick(flt_tick),
    .flt_bus_mode(flt_bus_mode), .flt_bypass(flt_bypass), .rise_en(rise_en),
    .fall_en(fall_en), .snap_ack(snap_ack), .dout_filt(dout_filt),
    .chg_event(chg_event), .snap_data(snap_data), .overrun(overrun)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input logic ok, input string tag, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_tick();
    @(negedge clk) flt_tick = 1'b1;
    @(negedge clk) flt_tick = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk) snap_ack = 1'b1;
    @(negedge clk) snap_ack = 1'b0;
  endtask

  // Driver side: expected snapshots go into the scoreboard queue
  task automatic expect_event(input logic [N-1:0] snap);
    exp_q.push_back(snap);
  endtask

  // Monitor: compares every event against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done && chg_event) begin
      n_evt++;
      if (exp_q.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R6 unexpected event actual=1 expected=0 snap=%h", snap_data);
      end else begin
        logic [N-1:0] e;
        e = exp_q.pop_front();
        check(snap_data == e, "R8 snapshot at event", snap_data, e);
      end
    end
  end

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0] cur;
    logic [N-1:0] wide;
    int           ev0;
    n_cmp = 0; n_bad = 0; n_evt = 0;
    rst_n = 1'b0; din_async = '0; flt_tick = 1'b0; flt_bus_mode = 1'b0;
    flt_bypass = '0; rise_en = '0; fall_en = '0; snap_ack = 1'b0;
    wait_cyc(3);
    check(dout_filt == '0, "R1 dout in reset", dout_filt, '0);
    check({overrun, chg_event} == 2'b00, "R1 flags in reset", {overrun, chg_event}, '0);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(5);
    check(snap_data == '0, "R1 snapshot after reset", snap_data, '0);
    check(dout_filt == '0, "R1 dout after reset", dout_filt, '0);

    // R2: single line step, one tick is not enough, two qualify
    rise_en[0] = 1'b1;
    din_async[0] = 1'b1;
    wait_cyc(4);
    check(dout_filt == '0, "R2 no change without tick", dout_filt, '0);
    do_tick();
    check(dout_filt == '0, "R2 one tick not enough", dout_filt, '0);
    cur = 48'h1;
    expect_event(cur);
    do_tick();
    check(dout_filt == cur, "R2 two ticks qualify", dout_filt, cur);
    wait_cyc(3);
    do_ack();

    // R3: line mode, glitch on line 1 does not hold up line 2
    din_async[1] = 1'b1; din_async[2] = 1'b1;
    wait_cyc(4);
    do_tick();
    din_async[1] = 1'b0;
    wait_cyc(4);
    do_tick();
    cur = 48'h5;
    check(dout_filt == cur, "R3 line independence", dout_filt, cur);

    // R4: bus mode, glitch on line 4 defers line 3
    flt_bus_mode = 1'b1;
    din_async[3] = 1'b1; din_async[4] = 1'b1;
    wait_cyc(4);
    do_tick();
    din_async[4] = 1'b0;
    wait_cyc(4);
    do_tick();
    check(dout_filt == cur, "R4 pending line deferred by glitch", dout_filt, cur);
    do_tick();
    cur = 48'hD;
    check(dout_filt == cur, "R4 applied after stable bus", dout_filt, cur);
    flt_bus_mode = 1'b0;

    // R5 / R9: bypass line 5 follows synchronizer after two edges
    flt_bypass[5] = 1'b1;
    wait_cyc(2);
    @(negedge clk) din_async[5] = 1'b1;
    @(negedge clk);
    check(dout_filt == cur, "R9 not visible after one edge", dout_filt, cur);
    @(negedge clk);
    cur = 48'h2D;
    check(dout_filt == cur, "R5 R9 bypass visible after two edges", dout_filt, cur);

    // R6: falling edge on a rise-only line raises no event
    ev0 = n_evt;
    din_async[0] = 1'b0;
    wait_cyc(4);
    do_tick();
    do_tick();
    wait_cyc(3);
    cur = 48'h2C;
    check(dout_filt == cur, "R6 masked fall still filtered", dout_filt, cur);
    check(n_evt == ev0, "R6 masked edge no event", 48'(n_evt - ev0), '0);

    // R6: falling edge on a fall-enabled line raises an event
    fall_en[2] = 1'b1;
    din_async[2] = 1'b0;
    wait_cyc(4);
    cur = 48'h28;
    expect_event(cur);
    do_tick();
    do_tick();
    wait_cyc(3);
    check(n_evt == ev0 + 1, "R6 enabled fall event", 48'(n_evt - ev0), 48'h1);
    check(overrun == 1'b0, "R7 no overrun yet", 48'(overrun), '0);

    // R7: second event without ack sets overrun, ack does not clear it
    fall_en[5] = 1'b1;
    cur = 48'h08;
    expect_event(cur);
    @(negedge clk) din_async[5] = 1'b0;
    wait_cyc(5);
    check(overrun == 1'b1, "R7 overrun set", 48'(overrun), 48'h1);
    do_ack();
    wait_cyc(2);
    check(overrun == 1'b1, "R7 overrun sticky after ack", 48'(overrun), 48'h1);

    // R8: snapshot holds over an unmasked change
    rise_en = '0; fall_en = '0;
    din_async[1] = 1'b1;
    wait_cyc(4);
    do_tick();
    do_tick();
    wait_cyc(2);
    check(dout_filt == 48'h0A, "R2 line 1 qualified", dout_filt, 48'h0A);
    check(snap_data == 48'h08, "R8 snapshot held", snap_data, 48'h08);

    // R4 / R6: wide word in bus mode with all rising enables
    flt_bypass = '0;
    flt_bus_mode = 1'b1;
    rise_en = '1;
    wide = 48'hF0F0_1234_800B;
    din_async = wide;
    wait_cyc(4);
    expect_event(wide);
    do_tick();
    check(dout_filt == 48'h0A, "R4 wide word needs second tick", dout_filt, 48'h0A);
    do_tick();
    check(dout_filt == wide, "R4 wide word applied", dout_filt, wide);
    wait_cyc(3);
    do_ack();

    // R6: all lines fall in line mode with all falling enables
    flt_bus_mode = 1'b0;
    rise_en = '0; fall_en = '1;
    din_async = '0;
    wait_cyc(4);
    expect_event('0);
    do_tick();
    do_tick();
    wait_cyc(3);
    check(dout_filt == '0, "R3 all lines fall", dout_filt, '0);
    check(overrun == 1'b1, "R7 overrun still set", 48'(overrun), 48'h1);
    check(exp_q.size() == 0, "R6 all expected events seen", 48'(exp_q.size()), '0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule